// File: doc/BRIEF.md
# Multi-Context Configuration Store

This block keeps several complete configuration contexts for a coarse-grain array of processing cells. It decides which context currently drives the cells. A host loads configuration words into any slot that is not in use, one word per cycle. A built-in sequencer assigns the addresses, so the first word goes to address 0 and the last to address DEPTH-1. The cells index the active context with a word address and receive that word one cycle later.

Changing the context is a single-edge switch to a slot that is already resident, so no reload is needed. A load can run in the background while the array keeps executing from the active slot. A request for a slot that is still loading is held and applied once the load completes. A single-context mode is also provided: in that mode the array is stalled for the whole time any load is in progress. Configuration storage is separate from any sample data storage. Each slot is tracked as empty, loading, ready or active.

Top module: `ctx_store`

## Requirements
- R1: After reset no context is active: `ctx_ready`, `array_en`, `load_busy`, `wr_err` and `sw_err` are low, and `cfg_word` is 0.
- R2: Consecutive accepted writes to one slot fill addresses 0 to DEPTH-1 in order. `load_busy` goes high at the edge that takes the first word and low at the edge that takes word DEPTH-1. The slot is then ready.
- R3: `cfg_word` shows the active slot's word at `rd_addr` one cycle after the address is presented. While no slot is active it reads 0.
- R4: A switch request (`sw_req` with `sw_slot`) naming a ready slot makes it active on the next edge. `active_slot` and `ctx_ready` update together on that edge. The slot that was active before stays resident and can be switched back to without a reload.
- R5: While an inactive slot is loading outside single-context mode, `array_en` stays high and `cfg_word` keeps returning the active slot's contents.
- R6: A write to the active slot is not stored. `wr_err` pulses high for one cycle after it, and the active contents are unchanged.
- R7: A switch request naming a slot that is still loading is held. It takes effect on the edge after the edge that writes that slot's last word.
- R8: A switch request naming an empty slot is dropped, and `sw_err` pulses high for one cycle after it.
- R9: With `single_mode` high, `array_en` is low whenever `load_busy` is high. `array_en` is never high without `ctx_ready`.
- R10: While a load is in progress, a write naming any other slot is rejected with a `wr_err` pulse, and the load carries on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| single_mode | input | 1 | High: stall the array during any load |
| wr_en | input | 1 | Host configuration word valid |
| wr_slot | input | SLOT_W | Target slot of the host word |
| wr_data | input | WORD_W | Configuration word |
| sw_req | input | 1 | Switch request pulse |
| sw_slot | input | SLOT_W | Slot to make active |
| rd_addr | input | ADDR_W | Word index requested by the cells |
| cfg_word | output | WORD_W | Active-context word, one cycle latency |
| array_en | output | 1 | Cell array may execute |
| ctx_ready | output | 1 | A context is active |
| active_slot | output | SLOT_W | Index of the active slot |
| load_busy | output | 1 | A load is in progress |
| wr_err | output | 1 | Rejected-write pulse |
| sw_err | output | 1 | Rejected-switch pulse |

## Verification
A corrupted slot state becomes visible within one or two cycles. A slot wrongly seen as active turns a legal write into a `wr_err` pulse. A slot wrongly seen as ready applies a pending switch early, so `active_slot` changes before the last word of the load. A sequencer address that is off by one shows up only when the array reads the affected word after a switch. The bench therefore reads back first, middle and last addresses of every context it loads. A wrong stall term shows directly on `array_en` on the cycle after a load starts or ends.

// File: rtl/ctx_store_pkg.sv
package ctx_store_pkg;

    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_LOADING = 2'd1,
        SLOT_READY   = 2'd2,
        SLOT_ACTIVE  = 2'd3
    } slot_state_e;

    localparam int DEF_SLOTS  = 2;
    localparam int DEF_DEPTH  = 512;
    localparam int DEF_WORD_W = 32;

    function automatic int idx_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ctx_load_seq.sv
module ctx_load_seq #(
    parameter int NUM_SLOTS = ctx_store_pkg::DEF_SLOTS,
    parameter int DEPTH     = ctx_store_pkg::DEF_DEPTH,
    localparam int SLOT_W   = ctx_store_pkg::idx_width(NUM_SLOTS),
    localparam int ADDR_W   = ctx_store_pkg::idx_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              act_valid,
    input  logic [SLOT_W-1:0] act_slot,
    input  logic              sw_apply,
    input  logic [SLOT_W-1:0] sw_target,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              start,
    output logic              done,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              wr_err
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] cnt;
    logic              accept;
    logic              bad_slot, hit_active, hit_target, hit_other;

    always_comb begin
        bad_slot   = int'(wr_slot) >= NUM_SLOTS;
        hit_active = act_valid && (wr_slot == act_slot);
        hit_target = sw_apply && (wr_slot == sw_target);
        hit_other  = busy && (wr_slot != cur_slot);
        accept     = wr_en && !bad_slot && !hit_active && !hit_target && !hit_other;
        mem_we     = accept;
        mem_addr   = busy ? cnt : '0;
        start      = accept && !busy;
        done       = accept && busy && (cnt == LAST_ADDR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cur_slot <= '0;
            wr_err   <= 1'b0;
        end else begin
            wr_err <= wr_en && !accept;
            if (start) begin
                busy     <= 1'b1;
                cur_slot <= wr_slot;
                cnt      <= ADDR_W'(1);
            end else if (done) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (accept) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctx_switch_ctl.sv
module ctx_switch_ctl
    import ctx_store_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    localparam int SLOT_W   = idx_width(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_req,
    input  logic [SLOT_W-1:0] sw_slot,
    input  logic              start,
    input  logic [SLOT_W-1:0] start_slot,
    input  logic              done,
    input  logic [SLOT_W-1:0] done_slot,
    output logic              act_valid,
    output logic [SLOT_W-1:0] act_slot,
    output logic              sw_apply,
    output logic [SLOT_W-1:0] sw_target,
    output logic              sw_err
);
    slot_state_e       st [NUM_SLOTS];
    logic              pend_v;
    logic [SLOT_W-1:0] pend_slot;
    logic              req_ok;
    slot_state_e       req_st;

    always_comb begin
        req_ok = int'(sw_slot) < NUM_SLOTS;
        req_st = req_ok ? st[sw_slot] : SLOT_EMPTY;
        if (sw_req) begin
            sw_target = sw_slot;
            sw_apply  = req_st == SLOT_READY;
        end else begin
            sw_target = pend_slot;
            sw_apply  = pend_v && (st[pend_slot] == SLOT_READY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SLOTS; s++) st[s] <= SLOT_EMPTY;
            pend_v    <= 1'b0;
            pend_slot <= '0;
            act_valid <= 1'b0;
            act_slot  <= '0;
            sw_err    <= 1'b0;
        end else begin
            sw_err <= sw_req && (req_st == SLOT_EMPTY);
            if (sw_req) begin
                pend_v    <= req_st == SLOT_LOADING;
                pend_slot <= sw_slot;
            end else if (sw_apply) begin
                pend_v <= 1'b0;
            end
            if (sw_apply) begin
                act_valid <= 1'b1;
                act_slot  <= sw_target;
            end
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (start && start_slot == SLOT_W'(s))
                    st[s] <= SLOT_LOADING;
                else if (done && done_slot == SLOT_W'(s))
                    st[s] <= SLOT_READY;
                else if (sw_apply && sw_target == SLOT_W'(s))
                    st[s] <= SLOT_ACTIVE;
                else if (sw_apply && act_valid && act_slot == SLOT_W'(s))
                    st[s] <= SLOT_READY;
            end
        end
    end
endmodule

// File: rtl/ctx_cfg_mem.sv
module ctx_cfg_mem #(
    parameter int NUM_SLOTS = ctx_store_pkg::DEF_SLOTS,
    parameter int DEPTH     = ctx_store_pkg::DEF_DEPTH,
    parameter int WORD_W    = ctx_store_pkg::DEF_WORD_W,
    localparam int SLOT_W   = ctx_store_pkg::idx_width(NUM_SLOTS),
    localparam int ADDR_W   = ctx_store_pkg::idx_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] w_slot,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic [WORD_W-1:0] w_data,
    input  logic              act_valid,
    input  logic [SLOT_W-1:0] act_slot,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] bank_out [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bank
        logic [WORD_W-1:0] words [DEPTH];
        always_ff @(posedge clk) begin
            if (we && w_slot == SLOT_W'(g)) words[w_addr] <= w_data;
        end
        assign bank_out[g] = words[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst)            rd_data <= '0;
        else if (act_valid) rd_data <= bank_out[act_slot];
        else                rd_data <= '0;
    end
endmodule

// File: rtl/ctx_store.sv
module ctx_store #(
    parameter int NUM_SLOTS = ctx_store_pkg::DEF_SLOTS,
    parameter int DEPTH     = ctx_store_pkg::DEF_DEPTH,
    parameter int WORD_W    = ctx_store_pkg::DEF_WORD_W,
    localparam int SLOT_W   = ctx_store_pkg::idx_width(NUM_SLOTS),
    localparam int ADDR_W   = ctx_store_pkg::idx_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              single_mode,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              sw_req,
    input  logic [SLOT_W-1:0] sw_slot,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] cfg_word,
    output logic              array_en,
    output logic              ctx_ready,
    output logic [SLOT_W-1:0] active_slot,
    output logic              load_busy,
    output logic              wr_err,
    output logic              sw_err
);
    logic              mem_we, ld_start, ld_done, sw_apply;
    logic [ADDR_W-1:0] mem_addr;
    logic [SLOT_W-1:0] ld_slot, sw_target;

    ctx_load_seq #(.NUM_SLOTS(NUM_SLOTS), .DEPTH(DEPTH)) u_seq (
        .clk, .rst, .wr_en, .wr_slot,
        .act_valid(ctx_ready), .act_slot(active_slot),
        .sw_apply, .sw_target,
        .mem_we, .mem_addr, .busy(load_busy),
        .start(ld_start), .done(ld_done), .cur_slot(ld_slot), .wr_err
    );

    ctx_switch_ctl #(.NUM_SLOTS(NUM_SLOTS)) u_sw (
        .clk, .rst, .sw_req, .sw_slot,
        .start(ld_start), .start_slot(wr_slot),
        .done(ld_done), .done_slot(ld_slot),
        .act_valid(ctx_ready), .act_slot(active_slot),
        .sw_apply, .sw_target, .sw_err
    );

    ctx_cfg_mem #(.NUM_SLOTS(NUM_SLOTS), .DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
        .clk, .rst, .we(mem_we), .w_slot(wr_slot), .w_addr(mem_addr), .w_data(wr_data),
        .act_valid(ctx_ready), .act_slot(active_slot), .rd_addr, .rd_data(cfg_word)
    );

    assign array_en = ctx_ready && !(single_mode && load_busy);
endmodule

// File: rtl/ctx_store_chk.sv
module ctx_store_chk #(
    parameter int SLOT_W = 1,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              single_mode,
    input logic              wr_en,
    input logic [SLOT_W-1:0] wr_slot,
    input logic [WORD_W-1:0] cfg_word,
    input logic              array_en,
    input logic              ctx_ready,
    input logic [SLOT_W-1:0] active_slot,
    input logic              load_busy,
    input logic              wr_err
);
    p_en_needs_ctx_r9: assert property (@(posedge clk) disable iff (rst)
        array_en |-> ctx_ready);

    p_single_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (single_mode && load_busy) |-> !array_en);

    p_bg_keeps_running_r5: assert property (@(posedge clk) disable iff (rst)
        (!single_mode && ctx_ready) |-> array_en);

    p_ctx_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        ctx_ready |=> ctx_ready);

    p_active_write_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctx_ready && wr_slot == active_slot) |=> wr_err);

    p_idle_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !ctx_ready |=> (cfg_word == '0));
endmodule

bind ctx_store ctx_store_chk #(.SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .single_mode(single_mode), .wr_en(wr_en), .wr_slot(wr_slot),
    .cfg_word(cfg_word), .array_en(array_en), .ctx_ready(ctx_ready),
    .active_slot(active_slot), .load_busy(load_busy), .wr_err(wr_err)
);

// File: tb/sim_ctx_store.sv
module sim_ctx_store;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 512;
    localparam int WORD_W = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        single_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_slot = '0;
    logic [31:0] wr_data = '0;
    logic        sw_req = 1'b0;
    logic [0:0]  sw_slot = '0;
    logic [8:0]  rd_addr = '0;
    logic [31:0] cfg_word;
    logic        array_en, ctx_ready, load_busy, wr_err, sw_err;
    logic [0:0]  active_slot;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model [2][DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_store #(.NUM_SLOTS(2), .DEPTH(DEPTH), .WORD_W(WORD_W)) u0 (
        .clk, .rst, .single_mode, .wr_en, .wr_slot, .wr_data, .sw_req, .sw_slot,
        .rd_addr, .cfg_word, .array_en, .ctx_ready, .active_slot, .load_busy,
        .wr_err, .sw_err
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int seed, input int i);
        return {16'(seed), 16'(i * 7 + 1)};
    endfunction

    // loads words first..last of a slot; mid-run checks of array_en and cfg_word
    task automatic load_range(input int slot, input int seed, input int first, input int last,
                              input logic exp_en, input int act_slot);
        for (int i = first; i <= last; i++) begin
            wr_en = 1'b1; wr_slot = 1'(slot); wr_data = pat(seed, i);
            tick();
            model[slot][i] = pat(seed, i);
            if (i == first + 20) begin
                chk("R2 busy mid-load", 32'(load_busy), 32'd1);
                chk("R5/R9 array_en mid-load", 32'(array_en), 32'(exp_en));
                if (act_slot >= 0)
                    chk("R5 active word during load", cfg_word, model[act_slot][rd_addr]);
            end
        end
        wr_en = 1'b0;
    endtask

    task automatic switch_to(input int slot);
        sw_req = 1'b1; sw_slot = 1'(slot);
        tick();
        sw_req = 1'b0;
    endtask

    task automatic read_chk(input string req, input int slot, input int addr);
        rd_addr = 9'(addr);
        tick();
        chk(req, cfg_word, model[slot][addr]);
    endtask

    task automatic t_reset();
        chk("R1 ctx_ready", 32'(ctx_ready), 32'd0);
        chk("R1 array_en", 32'(array_en), 32'd0);
        chk("R1 load_busy", 32'(load_busy), 32'd0);
        chk("R1 wr_err", 32'(wr_err), 32'd0);
        chk("R1 sw_err", 32'(sw_err), 32'd0);
        chk("R1 R3 cfg_word idle", cfg_word, 32'd0);
    endtask

    task automatic t_switch_empty();
        switch_to(1);
        chk("R8 sw_err pulse", 32'(sw_err), 32'd1);
        chk("R8 no context", 32'(ctx_ready), 32'd0);
        tick();
        chk("R8 sw_err cleared", 32'(sw_err), 32'd0);
    endtask

    task automatic t_first_load_and_other_reject();
        load_range(0, 16'h1111, 0, 2, 1'b0, -1);
        wr_en = 1'b1; wr_slot = 1'b1; wr_data = 32'hBAD0_0001;
        tick();
        wr_en = 1'b0;
        chk("R10 wr_err other slot", 32'(wr_err), 32'd1);
        chk("R10 load continues", 32'(load_busy), 32'd1);
        load_range(0, 16'h1111, 3, DEPTH - 1, 1'b0, -1);
        chk("R2 busy low after last", 32'(load_busy), 32'd0);
        chk("R2 still no context", 32'(ctx_ready), 32'd0);
        rd_addr = 9'd7; tick();
        chk("R3 idle cfg_word zero", cfg_word, 32'd0);
    endtask

    task automatic t_first_switch();
        switch_to(0);
        chk("R4 ctx_ready", 32'(ctx_ready), 32'd1);
        chk("R4 active_slot", 32'(active_slot), 32'd0);
        chk("R4 array_en", 32'(array_en), 32'd1);
        read_chk("R3 R2 word 0", 0, 0);
        read_chk("R3 R2 word 3", 0, 3);
        read_chk("R3 R2 word 100", 0, 100);
        read_chk("R3 R2 word last", 0, DEPTH - 1);
    endtask

    task automatic t_background();
        rd_addr = 9'd5; tick();
        load_range(1, 16'h2222, 0, DEPTH - 1, 1'b1, 0);
        chk("R2 busy low slot1", 32'(load_busy), 32'd0);
        chk("R5 still active 0", 32'(active_slot), 32'd0);
    endtask

    task automatic t_active_reject();
        wr_en = 1'b1; wr_slot = 1'b0; wr_data = 32'hDEAD_BEEF;
        tick();
        wr_en = 1'b0;
        chk("R6 wr_err pulse", 32'(wr_err), 32'd1);
        chk("R6 no load started", 32'(load_busy), 32'd0);
        tick();
        chk("R6 wr_err one cycle", 32'(wr_err), 32'd0);
        read_chk("R6 active word 0 intact", 0, 0);
    endtask

    task automatic t_back_and_forth();
        switch_to(1);
        chk("R4 active 1", 32'(active_slot), 32'd1);
        read_chk("R4 slot1 word 0", 1, 0);
        read_chk("R4 slot1 word last", 1, DEPTH - 1);
        switch_to(0);
        chk("R4 back to 0", 32'(active_slot), 32'd0);
        read_chk("R4 resident slot0 word 200", 0, 200);
    endtask

    task automatic t_pending();
        load_range(1, 16'h3333, 0, 99, 1'b1, 0);
        sw_req = 1'b1; sw_slot = 1'b1;
        load_range(1, 16'h3333, 100, 100, 1'b1, 0);
        sw_req = 1'b0;
        chk("R7 held while loading", 32'(active_slot), 32'd0);
        load_range(1, 16'h3333, 101, DEPTH - 1, 1'b1, 0);
        chk("R7 not yet at last-word edge", 32'(active_slot), 32'd0);
        tick();
        chk("R7 applied next edge", 32'(active_slot), 32'd1);
        chk("R7 ready", 32'(ctx_ready), 32'd1);
        read_chk("R7 new slot1 word 0", 1, 0);
        read_chk("R7 new slot1 word 300", 1, 300);
    endtask

    task automatic t_single();
        single_mode = 1'b1;
        tick();
        chk("R9 en before load", 32'(array_en), 32'd1);
        load_range(0, 16'h4444, 0, DEPTH - 1, 1'b0, -1);
        chk("R9 en after load", 32'(array_en), 32'd1);
        single_mode = 1'b0;
        switch_to(0);
        read_chk("R9 R2 reloaded slot0 last", 0, DEPTH - 1);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_switch_empty();
        t_first_load_and_other_reject();
        t_first_switch();
        t_background();
        t_active_reject();
        t_back_and_forth();
        t_pending();
        t_single();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule